// File: doc/BRIEF.md
# Interrupt Enable and Skip-Test Unit

This block keeps the 4-bit interrupt enable register of a small microcontroller core. It also keeps one pending flag for each of three request sources: external input 0, timer 1 and timer 2. The core loads the register from its 4-bit accumulator and copies it back to the accumulator. A source event sets that source's flag, and the flag stays set until something clears it. The block raises an interrupt request toward the core when a set flag is enabled and the core's global interrupt enable is on.

Each enable bit also decides how polling works. When a source is enabled for interrupts, the core's "skip if flag set" test for that source acts as a no-operation and never skips. When the source is disabled, the test works: it reports a skip in the same cycle and clears the flag. When several enabled requests wait at once, the block serves them in a fixed order.

All pins are plain control and status pins. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. A pulse on an input acts in the cycle in which it is high.

Top module: `irq_skip_unit`

## Requirements
- R1: Source codes are external 0 = 0, timer 1 = 1 and timer 2 = 2. Code 0 is enabled by register bit 0, code 1 by register bit 2 and code 2 by register bit 3. Event input bit i belongs to source code i.
- R2: A write pulse loads `acc_wdata_i` into the register. From the next cycle `acc_rdata_o` shows all four bits, including bit 1, which controls nothing. With no write, the register holds its value.
- R3: The register is 0000 after reset. It also becomes 0000 on the cycle after `standby_i` is high, and `standby_i` takes priority over a write in the same cycle.
- R4: An event pulse sets its source's flag from the next cycle, and the flag stays set until it is cleared. An event in the same cycle as a clear of that flag leaves the flag set.
- R5: A skip test on a source whose enable bit is 0 raises `skip_o` in the same cycle exactly when that source's flag is set. A test with select code 3 never skips and has no effect.
- R6: A skip test on a source whose enable bit is 1 never raises `skip_o` and leaves the flag unchanged.
- R7: A skip test that raises `skip_o` clears the tested flag on the next cycle.
- R8: `irq_o` is 1 exactly when some flag is set, its enable bit is 1 and `gie_i` is 1.
- R9: While `irq_o` is 1, `irq_src_o` gives the lowest-coded pending enabled source (external 0 first, then timer 1, then timer 2). While `irq_o` is 0, `irq_src_o` is 3.
- R10: `irq_ack_i` while `irq_o` is 1 clears only the flag named by `irq_src_o`. `irq_ack_i` while `irq_o` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Low-power entry pulse that clears the enable register |
| acc_wr_i | input | 1 | Write pulse that loads the register from the accumulator |
| acc_wdata_i | input | 4 | Accumulator value to write |
| acc_rdata_o | output | 4 | Current register value, for copying back to the accumulator |
| ev_i | input | 3 | One-cycle event pulses, bit i for source code i |
| skip_test_i | input | 1 | Skip-test instruction is executing this cycle |
| skip_sel_i | input | 2 | Source code under test |
| skip_o | output | 1 | Skip the next instruction |
| gie_i | input | 1 | Global interrupt enable from the core |
| irq_o | output | 1 | Interrupt request to the core |
| irq_src_o | output | 2 | Source code of the request being served |
| irq_ack_i | input | 1 | Core takes the interrupt this cycle |

## Verification
Directed sequences cover the main corner cases:
- A flag is tested under each enable setting, which separates a working test from a no-operation.
- An event arrives in the same cycle as a skip that clears its flag, which shows whether set or clear wins.
- All three sources are made pending together and acknowledged one at a time, which exposes the service order and any clearing of the wrong flag.
- A write to bit 1 reads back, and a write coincides with standby, which checks the unused bit and the priority of standby.

Seeded random traffic then mixes writes, events, tests, acknowledges and toggling of the global enable. A reference model in the bench predicts every output in every cycle, which catches mismatched enable bit positions and a missing global gate.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned REG_W   = 4;
  localparam int unsigned SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_EXT0 = 2'd0,
    SRC_TMR1 = 2'd1,
    SRC_TMR2 = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  // Register bit that enables a given source code.
  function automatic int unsigned en_pos(input int unsigned src);
    case (src)
      0:       return 0;
      1:       return 2;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/irqu_en_reg.sv
module irqu_en_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         standby_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (standby_i) q <= '0;
    else if (wr_i)      q <= wdata_i;
  end

  assign q_o = q;
endmodule

// File: rtl/irqu_flag_bank.sv
module irqu_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic f;
    // a new event wins over a clear so that no request is lost
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        f <= 1'b0;
      else if (set_i[g]) f <= 1'b1;
      else if (clr_i[g]) f <= 1'b0;
    end
    assign q_o[g] = f;
  end
endmodule

// File: rtl/irqu_skip_eval.sv
module irqu_skip_eval #(
  parameter int unsigned N  = 3,
  parameter int unsigned SW = 2
) (
  input  logic          test_i,
  input  logic [SW-1:0] sel_i,
  input  logic [N-1:0]  flags_i,
  input  logic [N-1:0]  ena_i,
  output logic          skip_o,
  output logic [N-1:0]  clr_o
);
  always_comb begin
    clr_o = '0;
    for (int i = 0; i < N; i++) begin
      if (test_i && sel_i == SW'(i) && !ena_i[i] && flags_i[i]) clr_o[i] = 1'b1;
    end
    skip_o = |clr_o;
  end
endmodule

// File: rtl/irqu_prio_enc.sv
module irqu_prio_enc #(
  parameter int unsigned N  = 3,
  parameter int unsigned SW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [SW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '1;
    // scan downward so the lowest code is left in idx_o
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = SW'(i);
    end
  end
endmodule

// File: rtl/irq_skip_unit.sv
module irq_skip_unit
  import irqu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic             acc_wr_i,
  input  logic [REG_W-1:0] acc_wdata_i,
  output logic [REG_W-1:0] acc_rdata_o,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic             skip_test_i,
  input  logic [SEL_W-1:0] skip_sel_i,
  output logic             skip_o,
  input  logic             gie_i,
  output logic             irq_o,
  output logic [SEL_W-1:0] irq_src_o,
  input  logic             irq_ack_i
);
  logic [REG_W-1:0]   en_q;
  logic [NUM_SRC-1:0] ena;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] skip_clr;
  logic [NUM_SRC-1:0] ack_clr;
  logic [NUM_SRC-1:0] pend;

  irqu_en_reg #(.W(REG_W)) u_en (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i),
    .wr_i(acc_wr_i), .wdata_i(acc_wdata_i), .q_o(en_q)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ena
    assign ena[g]     = en_q[en_pos(g)];
    assign pend[g]    = flag_q[g] & ena[g] & gie_i;
    assign ack_clr[g] = irq_ack_i & irq_o & (irq_src_o == SEL_W'(g));
  end

  irqu_skip_eval #(.N(NUM_SRC), .SW(SEL_W)) u_skip (
    .test_i(skip_test_i), .sel_i(skip_sel_i), .flags_i(flag_q),
    .ena_i(ena), .skip_o(skip_o), .clr_o(skip_clr)
  );

  irqu_prio_enc #(.N(NUM_SRC), .SW(SEL_W)) u_prio (
    .req_i(pend), .any_o(irq_o), .idx_o(irq_src_o)
  );

  irqu_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(ev_i),
    .clr_i(skip_clr | ack_clr), .q_o(flag_q)
  );

  assign acc_rdata_o = en_q;
endmodule

// File: rtl/irqu_chk.sv
module irqu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       standby_i,
  input logic       acc_wr_i,
  input logic [3:0] acc_wdata_i,
  input logic [3:0] acc_rdata_o,
  input logic [2:0] ev_i,
  input logic       skip_test_i,
  input logic [1:0] skip_sel_i,
  input logic       skip_o,
  input logic       gie_i,
  input logic       irq_o,
  input logic [1:0] irq_src_o,
  input logic       irq_ack_i,
  input logic [2:0] flag_q
);
  p_standby_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> acc_rdata_o == 4'd0);
  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr_i && !standby_i) |=> acc_rdata_o == $past(acc_wdata_i));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_wr_i && !standby_i) |=> $stable(acc_rdata_o));
  p_nop_ext0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_test_i && skip_sel_i == 2'd0 && acc_rdata_o[0]) |-> !skip_o);
  p_nop_tmr1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_test_i && skip_sel_i == 2'd1 && acc_rdata_o[2]) |-> !skip_o);
  p_nop_tmr2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_test_i && skip_sel_i == 2'd2 && acc_rdata_o[3]) |-> !skip_o);
  p_sel3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_test_i && skip_sel_i == 2'd3) |-> !skip_o);
  p_irq_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> !irq_o);
  p_src_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_src_o != 2'd3);
  p_src_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> irq_src_o == 2'd3);

  for (genvar g = 0; g < 3; g++) begin : g_src
    p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[g] |=> flag_q[g]);
    p_skip_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_o && skip_sel_i == 2'(g) && !ev_i[g]) |=> !flag_q[g]);
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && irq_ack_i && irq_src_o == 2'(g) && !ev_i[g]) |=> !flag_q[g]);
  end
endmodule

bind irq_skip_unit irqu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .acc_wr_i(acc_wr_i),
  .acc_wdata_i(acc_wdata_i), .acc_rdata_o(acc_rdata_o), .ev_i(ev_i),
  .skip_test_i(skip_test_i), .skip_sel_i(skip_sel_i), .skip_o(skip_o),
  .gie_i(gie_i), .irq_o(irq_o), .irq_src_o(irq_src_o),
  .irq_ack_i(irq_ack_i), .flag_q(flag_q)
);

// File: tb/sim_irq_skip_unit.sv
module sim_irq_skip_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, standby_i, acc_wr_i, skip_test_i, gie_i, irq_ack_i;
  logic [3:0] acc_wdata_i, acc_rdata_o;
  logic [2:0] ev_i;
  logic [1:0] skip_sel_i, irq_src_o;
  logic       skip_o, irq_o;

  irq_skip_unit u0 (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .acc_wr_i(acc_wr_i),
    .acc_wdata_i(acc_wdata_i), .acc_rdata_o(acc_rdata_o), .ev_i(ev_i),
    .skip_test_i(skip_test_i), .skip_sel_i(skip_sel_i), .skip_o(skip_o),
    .gie_i(gie_i), .irq_o(irq_o), .irq_src_o(irq_src_o), .irq_ack_i(irq_ack_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] m_en;
  logic [2:0] m_fl;
  logic       o_skip, o_irq;
  logic [1:0] o_src;
  logic [3:0] o_rd;

  // R1: enable bit for each source code
  function automatic logic m_ena(input int s);
    return (s == 0) ? m_en[0] : (s == 1) ? m_en[2] : m_en[3];
  endfunction
  function automatic logic e_skip(input logic t, input logic [1:0] sel);
    return t && sel != 2'd3 && !m_ena(int'(sel)) && m_fl[sel];
  endfunction
  function automatic logic [2:0] e_pend(input logic g);
    return m_fl & {m_ena(2), m_ena(1), m_ena(0)} & {3{g}};
  endfunction
  function automatic logic [1:0] e_src(input logic [2:0] p);
    return p[0] ? 2'd0 : p[1] ? 2'd1 : p[2] ? 2'd2 : 2'd3;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic wr, input logic [3:0] wd, input logic sb,
                       input logic [2:0] ev, input logic t, input logic [1:0] sel,
                       input logic g, input logic ack);
    logic [2:0] clr, p;
    logic       es;
    acc_wr_i = wr; acc_wdata_i = wd; standby_i = sb; ev_i = ev;
    skip_test_i = t; skip_sel_i = sel; gie_i = g; irq_ack_i = ack;
    #1;
    o_skip = skip_o; o_irq = irq_o; o_src = irq_src_o; o_rd = acc_rdata_o;
    es = e_skip(t, sel);
    p  = e_pend(g);
    check("R2 readback", int'(o_rd), int'(m_en));
    if (t && sel != 2'd3 && m_ena(int'(sel))) check("R6 skip", int'(o_skip), int'(es));
    else check("R5 skip", int'(o_skip), int'(es));
    check("R8 irq", int'(o_irq), int'(|p));
    check("R9 src", int'(o_src), int'(e_src(p)));
    clr = 3'b000;
    if (es) clr[sel] = 1'b1;
    if (ack && |p) clr[e_src(p)] = 1'b1;
    @(posedge clk);
    m_fl = (m_fl & ~clr) | ev;
    m_en = sb ? 4'd0 : (wr ? wd : m_en);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; acc_wr_i = 0; acc_wdata_i = 0; standby_i = 0; ev_i = 0;
    skip_test_i = 0; skip_sel_i = 0; gie_i = 0; irq_ack_i = 0;
    m_en = 4'd0; m_fl = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 reset state
    cycle(0, 4'h0, 0, 3'b000, 0, 2'd0, 1, 0);
    check("R3 reset reg", int'(o_rd), 0);
    check("R3 reset irq", int'(o_irq), 0);
    // R2 unused bit 1 keeps its value
    cycle(1, 4'b0010, 0, 3'b000, 0, 2'd0, 1, 0);
    cycle(0, 4'h0, 0, 3'b000, 0, 2'd0, 1, 0);
    check("R2 bit1", int'(o_rd), 2);
    // R5 / R7 valid test on timer 1 with interrupts disabled
    cycle(1, 4'b0000, 0, 3'b010, 0, 2'd0, 1, 0);
    cycle(0, 4'h0, 0, 3'b000, 1, 2'd1, 1, 0);
    check("R5 skip taken", int'(o_skip), 1);
    cycle(0, 4'h0, 0, 3'b000, 1, 2'd1, 1, 0);
    check("R7 flag consumed", int'(o_skip), 0);
    // R4 event coinciding with a clearing skip keeps the flag
    cycle(0, 4'h0, 0, 3'b010, 0, 2'd0, 1, 0);
    cycle(0, 4'h0, 0, 3'b010, 1, 2'd1, 1, 0);
    check("R4 skip on set flag", int'(o_skip), 1);
    cycle(0, 4'h0, 0, 3'b000, 1, 2'd1, 1, 0);
    check("R4 set wins clear", int'(o_skip), 1);
    // R6 / R8 / R1 timer 1 enabled via bit 2
    cycle(1, 4'b0100, 0, 3'b010, 0, 2'd0, 0, 0);
    cycle(0, 4'h0, 0, 3'b000, 1, 2'd1, 0, 0);
    check("R6 nop when enabled", int'(o_skip), 0);
    check("R8 gie off", int'(o_irq), 0);
    cycle(0, 4'h0, 0, 3'b000, 0, 2'd0, 1, 0);
    check("R1 tmr1 on bit2", int'(o_irq), 1);
    check("R1 tmr1 code", int'(o_src), 1);
    // R9 / R10 order of service
    cycle(1, 4'b1101, 0, 3'b111, 0, 2'd0, 1, 0);
    cycle(0, 4'h0, 0, 3'b000, 0, 2'd0, 1, 1);
    check("R9 ext0 first", int'(o_src), 0);
    cycle(0, 4'h0, 0, 3'b000, 0, 2'd0, 1, 1);
    check("R10 then tmr1", int'(o_src), 1);
    cycle(0, 4'h0, 0, 3'b000, 0, 2'd0, 1, 1);
    check("R10 then tmr2", int'(o_src), 2);
    cycle(0, 4'h0, 0, 3'b000, 0, 2'd0, 1, 1);
    check("R10 all served", int'(o_irq), 0);
    // R3 standby wins over a write
    cycle(1, 4'b1111, 1, 3'b000, 0, 2'd0, 1, 0);
    cycle(0, 4'h0, 0, 3'b001, 0, 2'd0, 1, 0);
    check("R3 standby clear", int'(o_rd), 0);
    // R5 select code 3 is a no-op
    cycle(0, 4'h0, 0, 3'b000, 1, 2'd3, 1, 0);
    check("R5 sel3", int'(o_skip), 0);
    cycle(0, 4'h0, 0, 3'b000, 1, 2'd0, 1, 0);
    check("R5 ext0 still set", int'(o_skip), 1);
    // constrained random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] ev;
      ev[0] = ($urandom % 4) == 0;
      ev[1] = ($urandom % 4) == 0;
      ev[2] = ($urandom % 4) == 0;
      cycle(($urandom % 8) == 0, 4'($urandom), ($urandom % 64) == 0, ev,
            ($urandom % 2) == 0, 2'($urandom), ($urandom % 4) != 0,
            ($urandom % 2) == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule